// File: doc/BRIEF.md
# Flash Program Request Window Checker

This block screens one flash programming request before it reaches the programming sequencer. A request names a start address in 16-bit words, a word count, a programming mode and, for modes that carry check bytes, which check-byte slots the caller supplies. It also carries a flag saying the target lies in a bit-updatable pointer region. The block decides whether the request is legal. It reports a reason code when it is not. When the request is legal it produces the per-word lane enables and the per-half select for the 128-bit block the request falls in, together with the mode the sequencer should actually use.

Flash is written in aligned 128-bit blocks of eight 16-bit words. Each 64-bit half of a block has its own check byte: the lower byte guards words 0 to 3 and the upper byte guards words 4 to 7. There are four modes, encoded as 0 = data only, 1 = data with generated check byte, 2 = data with supplied check bytes, 3 = check bytes only. Requests into pointer regions are always downgraded to data only, so those words stay programmable one bit at a time. The block also presents the start address converted to a byte address, which is the form the check-code generator expects. All results are registered once and come with a one-cycle valid strobe.

Top module: `flash_prog_window_check`

## Requirements
- R1: Each cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the next clock edge. In any cycle without a response, and after reset, every `rsp_*` output is zero.
- R2: The word offset is the address modulo 8. A request whose mode (after demotion) uses data words is rejected with error code 1 (window) if the count is 0 or if offset + count exceeds 8.
- R3: In data-only mode (0), any in-window count of 1 to 8 words is accepted. `rsp_word_en` bit k is set for k from offset to offset + count − 1. `rsp_half_sel` bit 0 is set when any of words 0–3 is enabled, and bit 1 when any of words 4–7 is enabled.
- R4: In generated-check mode (1), the offset must be 0 or 4 and the count must be at least 4; otherwise the request is rejected with code 2 (alignment). When the request is accepted, every word of each touched half is enabled, because the words not supplied are filled with ones.
- R5: In supplied-check mode (2), only three shapes are accepted: offset 0 with 4 words, offset 4 with 4 words, and offset 0 with 8 words. Any other in-window shape gives code 2. The check-byte select (bit 0 = first byte slot, bit 1 = second slot) must then be 01 for a half and 11 for a full block. The value 10 gives code 4 (upper byte only); any other mismatch gives code 3 (byte count).
- R6: In check-only mode (3), the word count is ignored and `rsp_word_en` is zero. The offset must be 0 or 4, or code 2 results. A select of 10 gives code 4 and a select of 00 gives code 3. At offset 0, select 01 sets half select 01 and select 11 sets half select 11. At offset 4, select 01 sets half select 10 and select 11 gives code 3.
- R7: With `req_link` high, the effective mode is data only (0) whatever `req_mode` is, and the data-only rules of R2 and R3 apply. `rsp_mode` always reports the effective mode.
- R8: `rsp_byte_addr` equals the request word address shifted left by one bit.
- R9: An accepted request has `rsp_err` 0. A rejected request has `rsp_accept` 0 and both masks zero. Where several faults apply, window is reported before alignment, alignment before upper-byte-only, and upper-byte-only before byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Start address in 16-bit words |
| req_count | input | CNT_W | Number of 16-bit words |
| req_mode | input | 2 | Requested programming mode |
| req_chk_sel | input | 2 | Check-byte slots supplied (bit 0 first, bit 1 second) |
| req_link | input | 1 | Target lies in a bit-updatable pointer region |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_accept | output | 1 | Request is legal |
| rsp_err | output | 3 | 0 none, 1 window, 2 alignment, 3 byte count, 4 upper byte only |
| rsp_half_sel | output | 2 | 64-bit halves to program |
| rsp_word_en | output | BLOCK_WORDS | 16-bit lanes to program |
| rsp_mode | output | 2 | Effective mode after demotion |
| rsp_byte_addr | output | ADDR_W+1 | Start address as a byte address |

## Verification
The cases hardest to reach are the ones where several faults overlap. Examples are a supplied-check request that is both misaligned and carries an upper-only select, or a pointer-region request whose original mode would have failed a check-byte rule that demotion removes. Uniform random stimulus rarely hits these shapes. The stimulus therefore draws offsets from the half boundaries, counts from {0, 4, 8} and the select from its four values more often than from the rest. Directed requests cover each priority pair, the demoted check-only request, and an offset-4 request whose count overruns the block.

// File: rtl/flashwin_pkg.sv
package flashwin_pkg;
   typedef enum logic [1:0] {
      PM_DATA     = 2'd0,
      PM_DATA_GEN = 2'd1,
      PM_DATA_SUP = 2'd2,
      PM_CHK_ONLY = 2'd3
   } pmode_e;

   typedef enum logic [2:0] {
      FE_NONE   = 3'd0,
      FE_WINDOW = 3'd1,
      FE_ALIGN  = 3'd2,
      FE_BYTES  = 3'd3,
      FE_UPPER  = 3'd4
   } ferr_e;
endpackage

// File: rtl/flashwin_span.sv
module flashwin_span #(
   parameter int BLOCK_WORDS = 8,
   parameter int OFS_W       = 3,
   parameter int CNT_W       = 4
) (
   input  logic [OFS_W-1:0]       ofs,
   input  logic [CNT_W-1:0]       cnt,
   output logic                   overflow,
   output logic [BLOCK_WORDS-1:0] lanes,
   output logic [1:0]             halves
);
   localparam int HALF  = BLOCK_WORDS / 2;
   localparam int END_W = CNT_W + 1;

   logic [END_W-1:0] stop;
   assign stop     = END_W'(ofs) + END_W'(cnt);
   assign overflow = (cnt == '0) || (stop > END_W'(BLOCK_WORDS));

   generate
      for (genvar i = 0; i < BLOCK_WORDS; i++) begin : g_lane
         localparam logic [END_W-1:0] IDX = END_W'(i);
         assign lanes[i] = (IDX >= END_W'(ofs)) && (IDX < stop);
      end
   endgenerate

   assign halves[0] = |lanes[HALF-1:0];
   assign halves[1] = |lanes[BLOCK_WORDS-1:HALF];
endmodule

// File: rtl/flashwin_rules.sv
module flashwin_rules
   import flashwin_pkg::*;
#(
   parameter int BLOCK_WORDS = 8,
   parameter int OFS_W       = 3,
   parameter int CNT_W       = 4
) (
   input  pmode_e                 mode,
   input  logic                   link,
   input  logic [OFS_W-1:0]       ofs,
   input  logic [CNT_W-1:0]       cnt,
   input  logic [1:0]             sel,
   input  logic                   overflow,
   input  logic [BLOCK_WORDS-1:0] lanes,
   input  logic [1:0]             halves,
   output logic                   ok,
   output ferr_e                  err,
   output logic [1:0]             half_out,
   output logic [BLOCK_WORDS-1:0] we,
   output pmode_e                 eff
);
   localparam int HALF = BLOCK_WORDS / 2;

   logic on_half, upper_start, full_shape, half_shape;
   logic [1:0] need_sel;
   logic [1:0] hsel;
   logic [BLOCK_WORDS-1:0] wmask;

   assign on_half     = (ofs[OFS_W-2:0] == '0);
   assign upper_start = ofs[OFS_W-1];
   assign half_shape  = on_half && (cnt == CNT_W'(HALF));
   assign full_shape  = (ofs == '0) && (cnt == CNT_W'(BLOCK_WORDS));
   assign need_sel    = full_shape ? 2'b11 : 2'b01;
   assign eff         = link ? PM_DATA : mode;

   always_comb begin
      err   = FE_NONE;
      hsel  = halves;
      wmask = lanes;
      unique case (eff)
         PM_DATA: begin
            if (overflow) err = FE_WINDOW;
         end
         PM_DATA_GEN: begin
            if (overflow)                             err = FE_WINDOW;
            else if (!on_half || cnt < CNT_W'(HALF))  err = FE_ALIGN;
            wmask = {{HALF{halves[1]}}, {HALF{halves[0]}}};
         end
         PM_DATA_SUP: begin
            if (overflow)                          err = FE_WINDOW;
            else if (!(half_shape || full_shape))  err = FE_ALIGN;
            else if (sel == 2'b10)                 err = FE_UPPER;
            else if (sel != need_sel)              err = FE_BYTES;
         end
         default: begin
            wmask = '0;
            if (!on_half)                           err = FE_ALIGN;
            else if (sel == 2'b10)                  err = FE_UPPER;
            else if (sel == 2'b00)                  err = FE_BYTES;
            else if (upper_start && sel == 2'b11)   err = FE_BYTES;
            hsel = upper_start ? 2'b10 : sel;
         end
      endcase
   end

   assign ok       = (err == FE_NONE);
   assign half_out = ok ? hsel : 2'b00;
   assign we       = ok ? wmask : '0;
endmodule

// File: rtl/flash_prog_window_check.sv
module flash_prog_window_check
   import flashwin_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int BLOCK_WORDS = 8,
   parameter int OFS_W       = $clog2(BLOCK_WORDS),
   parameter int CNT_W       = OFS_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [CNT_W-1:0]       req_count,
   input  logic [1:0]             req_mode,
   input  logic [1:0]             req_chk_sel,
   input  logic                   req_link,
   output logic                   rsp_valid,
   output logic                   rsp_accept,
   output logic [2:0]             rsp_err,
   output logic [1:0]             rsp_half_sel,
   output logic [BLOCK_WORDS-1:0] rsp_word_en,
   output logic [1:0]             rsp_mode,
   output logic [ADDR_W:0]        rsp_byte_addr
);
   generate
      if (BLOCK_WORDS < 4 || (1 << OFS_W) != BLOCK_WORDS)
         $error("BLOCK_WORDS must be a power of two of at least 4");
      if (ADDR_W <= OFS_W)
         $error("ADDR_W must exceed the block offset width");
   endgenerate

   logic                   ovf, ok;
   logic [BLOCK_WORDS-1:0] lanes, we;
   logic [1:0]             halves, hsel;
   ferr_e                  err;
   pmode_e                 eff;

   flashwin_span #(.BLOCK_WORDS(BLOCK_WORDS), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_span (
      .ofs(req_addr[OFS_W-1:0]), .cnt(req_count),
      .overflow(ovf), .lanes(lanes), .halves(halves)
   );

   flashwin_rules #(.BLOCK_WORDS(BLOCK_WORDS), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_rules (
      .mode(pmode_e'(req_mode)), .link(req_link),
      .ofs(req_addr[OFS_W-1:0]), .cnt(req_count), .sel(req_chk_sel),
      .overflow(ovf), .lanes(lanes), .halves(halves),
      .ok(ok), .err(err), .half_out(hsel), .we(we), .eff(eff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_accept    <= 1'b0;
         rsp_err       <= 3'd0;
         rsp_half_sel  <= 2'b00;
         rsp_word_en   <= '0;
         rsp_mode      <= 2'd0;
         rsp_byte_addr <= '0;
      end else begin
         rsp_valid     <= req_valid;
         rsp_accept    <= req_valid && ok;
         rsp_err       <= req_valid ? err : FE_NONE;
         rsp_half_sel  <= req_valid ? hsel : 2'b00;
         rsp_word_en   <= req_valid ? we : '0;
         rsp_mode      <= req_valid ? eff : PM_DATA;
         rsp_byte_addr <= req_valid ? {req_addr, 1'b0} : '0;
      end
   end

   // R1
   strobe_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R1
   quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && rsp_word_en == '0 && rsp_err == 3'd0));
   // R7
   link_demotes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_link) |=> (rsp_mode == 2'd0));
   // R9
   reject_no_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_accept) |-> (rsp_word_en == '0 && rsp_half_sel == 2'b00 && rsp_err != 3'd0));
   // R4
   gen_whole_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_accept && rsp_mode == 2'd1) |->
      (rsp_word_en == {{(BLOCK_WORDS/2){rsp_half_sel[1]}}, {(BLOCK_WORDS/2){rsp_half_sel[0]}}}));
   // R6
   chk_only_no_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_accept && rsp_mode == 2'd3) |-> (rsp_word_en == '0 && rsp_half_sel != 2'b00));
   // R8
   byte_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_byte_addr == {$past(req_addr), 1'b0}));
endmodule

// File: tb/flash_prog_window_check_test.sv
module flash_prog_window_check_test;
   localparam int AW = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [3:0]    req_count = '0;
   logic [1:0]    req_mode = '0;
   logic [1:0]    req_chk_sel = '0;
   logic          req_link = 1'b0;
   logic          rsp_valid, rsp_accept;
   logic [2:0]    rsp_err;
   logic [1:0]    rsp_half_sel, rsp_mode;
   logic [7:0]    rsp_word_en;
   logic [AW:0]   rsp_byte_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   flash_prog_window_check #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_count(req_count), .req_mode(req_mode), .req_chk_sel(req_chk_sel),
      .req_link(req_link), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
      .rsp_err(rsp_err), .rsp_half_sel(rsp_half_sel), .rsp_word_en(rsp_word_en),
      .rsp_mode(rsp_mode), .rsp_byte_addr(rsp_byte_addr)
   );

   // expected {accept, err[2:0], half[1:0], we[7:0], mode[1:0]}
   function automatic logic [15:0] model(input int mode, input bit link, input int ofs,
                                         input int cnt, input int sel);
      int e = link ? 0 : mode;
      int err = 0;
      logic [7:0] we = '0;
      logic [1:0] hs = '0;
      bit win_bad = (cnt == 0) || (ofs + cnt > 8);
      if (e == 0) begin
         if (win_bad) err = 1;
      end else if (e == 1) begin
         if (win_bad) err = 1;
         else if (ofs % 4 != 0 || cnt < 4) err = 2;
      end else if (e == 2) begin
         if (win_bad) err = 1;
         else if (!((ofs == 0 && cnt == 4) || (ofs == 4 && cnt == 4) || (ofs == 0 && cnt == 8))) err = 2;
         else if (sel == 2) err = 4;
         else if (sel != ((cnt == 8) ? 3 : 1)) err = 3;
      end else begin
         if (ofs % 4 != 0) err = 2;
         else if (sel == 2) err = 4;
         else if (sel == 0) err = 3;
         else if (ofs == 4 && sel == 3) err = 3;
      end
      if (err == 0) begin
         if (e == 3) begin
            hs = (ofs == 4) ? 2'b10 : ((sel == 3) ? 2'b11 : 2'b01);
         end else begin
            for (int k = ofs; k < ofs + cnt; k++) we[k] = 1'b1;
            hs = {|we[7:4], |we[3:0]};
            if (e == 1) we = {{4{hs[1]}}, {4{hs[0]}}};
         end
      end
      return {(err == 0), 3'(err), hs, we, 2'(e)};
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic send(input string req, input int addr, input int cnt, input int mode,
                       input int sel, input bit link);
      logic [15:0] ex;
      int ofs = addr % 8;
      req_valid   = 1'b1;
      req_addr    = AW'(addr);
      req_count   = 4'(cnt);
      req_mode    = 2'(mode);
      req_chk_sel = 2'(sel);
      req_link    = link;
      ex = model(mode, link, ofs, cnt, sel);
      @(negedge clk);
      req_valid = 1'b0;
      check(req, {rsp_valid, rsp_accept, rsp_err, rsp_half_sel, rsp_word_en, rsp_mode},
            {1'b1, ex});
      check("R8", 64'(rsp_byte_addr), 64'(addr) << 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", {rsp_valid, rsp_accept, rsp_err, rsp_half_sel, rsp_word_en, rsp_mode}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      send("R3", 'h103, 3, 0, 0, 0);
      // R1 strobe falls after one cycle
      @(negedge clk);
      check("R1", {rsp_valid, rsp_word_en, rsp_err}, '0);
      send("R3", 'h007, 1, 0, 0, 0);
      send("R2", 'h005, 4, 0, 0, 0);
      send("R2", 'h000, 0, 0, 0, 0);
      send("R4", 'h004, 4, 1, 0, 0);
      send("R4", 'h000, 5, 1, 0, 0);
      send("R4", 'h002, 4, 1, 0, 0);
      send("R4", 'h000, 3, 1, 0, 0);
      send("R5", 'h000, 8, 2, 3, 0);
      send("R5", 'h004, 4, 2, 1, 0);
      send("R5", 'h000, 8, 2, 1, 0);
      send("R5", 'h001, 4, 2, 2, 0);
      send("R5", 'h000, 4, 2, 2, 0);
      send("R6", 'h004, 0, 3, 1, 0);
      send("R6", 'h004, 9, 3, 3, 0);
      send("R6", 'h000, 0, 3, 3, 0);
      send("R6", 'h000, 0, 3, 2, 0);
      send("R6", 'h000, 0, 3, 0, 0);
      send("R6", 'h003, 0, 3, 2, 0);
      send("R7", 'h013, 1, 3, 2, 1);
      send("R7", 'h001, 2, 2, 0, 1);
      send("R9", 'h006, 5, 2, 2, 0);
      for (int n = 0; n < 3000; n++) begin
         int a = $urandom_range(0, (1 << AW) - 1);
         int c = ($urandom_range(0, 3) == 0) ? 4 * $urandom_range(0, 2) : $urandom_range(0, 15);
         if ($urandom_range(0, 1) == 1) a = a & ~3;
         send("R9", a, c, $urandom_range(0, 3), $urandom_range(0, 3), ($urandom_range(0, 5) == 0));
      end
      done = 1'b1;
   end

   initial begin
      void'($urandom(32'h5EED_0123));
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule